// File: doc/BRIEF.md
# UART Receive Character Queue

This block holds received UART characters between the deserializer and the register interface. Each arriving character is stored together with four error tags (framing, parity, break, overrun) in a circular buffer. Software reads the oldest entry through a data-read port with a pop strobe. On each pop, the error tags of the entry that was read are latched into a receive-status output. The block drives full and empty flags and a receive-level interrupt request.

A mode input selects between two depths at run time. In buffered mode the whole ring is used. In holding-register mode only a single slot is used. Any change of the mode input flushes the ring. When the loopback input is high, characters and break events from the external deserializer are blocked, and characters and breaks arriving on a separate loopback path are queued instead.

Top module: `uart_rxq`

## Requirements
- R1: After reset, `buf_empty`=1, `buf_full`=0, `rx_irq`=0, `overrun`=0, `rd_err`=0 and `lvl_q`=6'h12.
- R2: Each entry is 12 bits wide. Bits [7:0] hold the character, bit 8 the framing tag, bit 9 the parity tag, bit 10 the break tag and bit 11 the overrun tag. Entries are read in the order they were accepted, and the ring wraps around.
- R3: `buf_empty` is 1 exactly when the count is zero. `buf_full` is 1 exactly when the count equals the effective depth, which is DEPTH in buffered mode and 1 in holding mode. Both flags change on the clock edge after the push or pop that causes them.
- R4: A push into a full buffer is dropped and the stored data is kept. `overrun` pulses for one cycle after the edge. The next accepted entry carries the overrun tag.
- R5: `rx_irq` rises on a push that brings the count to the trigger level. It falls on a pop that leaves the count one below the trigger level. The trigger level is TRIG_LEVEL (1 by default), whatever value is held in the level register.
- R6: `lvl_wr` loads `lvl_wdata` into `lvl_q`. That value does not affect the trigger.
- R7: When `fifo_on` changes value, the count and read position are zeroed, `buf_empty` is set and `buf_full` is cleared. Any push or pop in that same cycle is discarded. `rx_irq` keeps its value.
- R8: A break event pushes an entry with the character field 0 and only the break tag set. A break event in the same cycle as a character takes precedence over the character.
- R9: While `loop_on`=1, the external character strobe and the external break are ignored, and the loopback strobe and loopback break are queued. While `loop_on`=0, the loopback inputs are ignored.
- R10: On every pop, `rd_err` takes bits [11:8] of the entry at the read position. A pop on an empty buffer leaves the read position and count unchanged.
- R11: In holding-register mode every entry uses slot 0. A second push while a character is held is an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_on | input | 1 | 1 selects buffered mode, 0 selects holding-register mode |
| loop_on | input | 1 | Loopback select |
| rx_strobe | input | 1 | External character valid |
| rx_char | input | 8 | External character |
| rx_frm_err | input | 1 | Framing error tag for rx_char |
| rx_par_err | input | 1 | Parity error tag for rx_char |
| rx_break | input | 1 | External line break event |
| lb_strobe | input | 1 | Loopback character valid |
| lb_char | input | 8 | Loopback character |
| lb_break | input | 1 | Loopback break event |
| rd_pop | input | 1 | Read strobe that removes the head entry |
| rd_entry | output | 12 | Head entry (character and tags) |
| rd_err | output | 4 | Tags of the last popped entry, {ovr, brk, par, frm} |
| lvl_wr | input | 1 | Level register write strobe |
| lvl_wdata | input | 6 | Level register write value |
| lvl_q | output | 6 | Level register contents |
| buf_full | output | 1 | Count equals the effective depth |
| buf_empty | output | 1 | Count is zero |
| rx_irq | output | 1 | Receive-level interrupt request |
| overrun | output | 1 | One-cycle pulse after a dropped push |

## Verification
The bench builds the block with its default values, DEPTH=16 and TRIG_LEVEL=1. With sixteen slots, a full fill followed by a pop and a refill moves the write slot past the top of the ring. This exercises wraparound as well as overrun tagging. With a trigger of one, the interrupt toggles at the empty/non-empty boundary, which is where a programmed level of 6'h12 would differ visibly if it were used. Switching the mode input exercises the single-slot holding path, and shows that a stale interrupt survives the flush until a pop on the empty buffer clears it.

// File: rtl/uart_rxq_pkg.sv
// Shared widths and the entry layout of the receive queue.
package uart_rxq_pkg;
    localparam int CHAR_W  = 8;
    localparam int TAG_W   = 4;
    localparam int ENTRY_W = CHAR_W + TAG_W;
    localparam int LVL_W   = 6;
    localparam logic [LVL_W-1:0] LVL_RESET = 6'h12;

    // Bit 11 ovr, 10 brk, 9 par, 8 frm, 7:0 character.
    typedef struct packed {
        logic              ovr;
        logic              brk;
        logic              par;
        logic              frm;
        logic [CHAR_W-1:0] chr;
    } rx_entry_t;
endpackage

// File: rtl/uart_rxq_ingress.sv
// Picks the active source (external or loopback) and builds the entry to
// store. Assumes break and character strobes are single-cycle events.
module uart_rxq_ingress
    import uart_rxq_pkg::*;
(
    input  logic              loop_on,
    input  logic              ext_valid,
    input  logic [CHAR_W-1:0] ext_chr,
    input  logic              ext_frm,
    input  logic              ext_par,
    input  logic              ext_brk,
    input  logic              lb_valid,
    input  logic [CHAR_W-1:0] lb_chr,
    input  logic              lb_brk,
    output logic              push_req,
    output rx_entry_t         push_ent
);
    logic sel_valid;
    logic sel_brk;

    // Gate the external path during loopback, and the loopback path otherwise.
    always_comb begin
        sel_valid = loop_on ? lb_valid : ext_valid;
        sel_brk   = loop_on ? lb_brk   : ext_brk;
    end

    // Form the entry; a break overrides a character in the same cycle.
    always_comb begin
        push_req     = sel_valid | sel_brk;
        push_ent     = '0;
        if (sel_brk) begin
            push_ent.brk = 1'b1;
        end else begin
            push_ent.chr = loop_on ? lb_chr : ext_chr;
            push_ent.frm = loop_on ? 1'b0 : ext_frm;
            push_ent.par = loop_on ? 1'b0 : ext_par;
        end
    end
endmodule

// File: rtl/uart_rxq_ctrl.sv
// Read position, occupancy count, flags, mode-change flush and overrun
// handling. DEPTH must be a power of two; holding mode uses a depth of 1.
module uart_rxq_ctrl #(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_on,
    input  logic             push_req,
    input  logic             pop,
    output logic             push_acc,
    output logic             pop_seen,
    output logic [PTR_W-1:0] wr_slot,
    output logic [PTR_W-1:0] rd_pos,
    output logic             ovr_tag,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             full,
    output logic             empty,
    output logic             overrun
);
    logic             mode_q;
    logic             mode_chg;
    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] mask;
    logic             at_depth;
    logic             pop_eff;
    logic             drop;
    logic             ovr_pend;

    // Decode the effective depth and the accept/drop conditions for this cycle.
    always_comb begin
        mode_chg = fifo_on ^ mode_q;
        mask     = mode_q ? PTR_W'(DEPTH - 1) : '0;
        at_depth = mode_q ? (cnt == CNT_W'(DEPTH)) : (cnt == CNT_W'(1));
        push_acc = push_req & ~at_depth & ~mode_chg;
        drop     = push_req &  at_depth & ~mode_chg;
        pop_seen = pop & ~mode_chg;
        pop_eff  = pop_seen & (cnt != '0);
        wr_slot  = (rd_pos + cnt[PTR_W-1:0]) & mask;
        cnt_nxt  = cnt + CNT_W'(push_acc) - CNT_W'(pop_eff);
        ovr_tag  = ovr_pend;
    end

    // Hold the count, pointer, flags and pending overrun; flush on a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= fifo_on;
            cnt      <= '0;
            rd_pos   <= '0;
            full     <= 1'b0;
            empty    <= 1'b1;
            ovr_pend <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            mode_q  <= fifo_on;
            overrun <= drop;
            if (mode_chg) begin
                cnt      <= '0;
                rd_pos   <= '0;
                full     <= 1'b0;
                empty    <= 1'b1;
                ovr_pend <= 1'b0;
            end else begin
                cnt   <= cnt_nxt;
                empty <= (cnt_nxt == '0);
                full  <= mode_q ? (cnt_nxt == CNT_W'(DEPTH)) : (cnt_nxt == CNT_W'(1));
                if (pop_eff) begin
                    rd_pos <= (rd_pos + PTR_W'(1)) & mask;
                end
                if (push_acc) begin
                    ovr_pend <= 1'b0;
                end else if (drop) begin
                    ovr_pend <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_rxq_store.sv
// Entry storage with one write port and one read port, plus the receive-status
// register that latches the tags of each popped entry.
module uart_rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_slot,
    input  rx_entry_t        wr_ent,
    input  logic             ovr_tag,
    input  logic [PTR_W-1:0] rd_pos,
    input  logic             cap,
    output rx_entry_t        rd_ent,
    output logic [TAG_W-1:0] rd_err
);
    rx_entry_t mem [DEPTH];
    rx_entry_t wr_tagged;

    // Add the pending overrun tag to the entry being written.
    always_comb begin
        wr_tagged     = wr_ent;
        wr_tagged.ovr = wr_ent.ovr | ovr_tag;
        rd_ent        = mem[rd_pos];
    end

    // Write the accepted entry into its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_slot] <= wr_tagged;
        end
    end

    // Latch the tags of the head entry on every pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_err <= '0;
        end else if (cap) begin
            rd_err <= {rd_ent.ovr, rd_ent.brk, rd_ent.par, rd_ent.frm};
        end
    end
endmodule

// File: rtl/uart_rxq_trig.sv
// Level register and receive-level interrupt. The level register is kept for
// software but the comparison uses the fixed TRIG_LEVEL.
module uart_rxq_trig
    import uart_rxq_pkg::*;
#(
    parameter int TRIG_LEVEL = 1,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_acc,
    input  logic             pop_seen,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             lvl_wr,
    input  logic [LVL_W-1:0] lvl_wdata,
    output logic [LVL_W-1:0] lvl_q,
    output logic             irq
);
    localparam logic [CNT_W-1:0] TRIG_C  = CNT_W'(TRIG_LEVEL);
    localparam logic [CNT_W-1:0] TRIG_M1 = CNT_W'(TRIG_LEVEL - 1);

    // Store the programmed level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_RESET;
        end else if (lvl_wr) begin
            lvl_q <= lvl_wdata;
        end
    end

    // Raise on a push that reaches the trigger, drop on a pop that leaves one below it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (push_acc && cnt_nxt == TRIG_C) begin
            irq <= 1'b1;
        end else if (pop_seen && cnt_nxt == TRIG_M1) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rxq.sv
// Top level of the UART receive queue: ingress select, control, storage and
// trigger. Inputs are assumed to be synchronous to clk.
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int TRIG_LEVEL = 1,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_on,
    input  logic               loop_on,
    input  logic               rx_strobe,
    input  logic [CHAR_W-1:0]  rx_char,
    input  logic               rx_frm_err,
    input  logic               rx_par_err,
    input  logic               rx_break,
    input  logic               lb_strobe,
    input  logic [CHAR_W-1:0]  lb_char,
    input  logic               lb_break,
    input  logic               rd_pop,
    output logic [ENTRY_W-1:0] rd_entry,
    output logic [TAG_W-1:0]   rd_err,
    input  logic               lvl_wr,
    input  logic [LVL_W-1:0]   lvl_wdata,
    output logic [LVL_W-1:0]   lvl_q,
    output logic               buf_full,
    output logic               buf_empty,
    output logic               rx_irq,
    output logic               overrun
);
    logic             push_req;
    rx_entry_t        push_ent;
    logic             push_acc;
    logic             pop_seen;
    logic [PTR_W-1:0] wr_slot;
    logic [PTR_W-1:0] rd_pos;
    logic             ovr_tag;
    logic [CNT_W-1:0] cnt_nxt;
    rx_entry_t        head;

    uart_rxq_ingress u_ingress (
        .loop_on   (loop_on),
        .ext_valid (rx_strobe),
        .ext_chr   (rx_char),
        .ext_frm   (rx_frm_err),
        .ext_par   (rx_par_err),
        .ext_brk   (rx_break),
        .lb_valid  (lb_strobe),
        .lb_chr    (lb_char),
        .lb_brk    (lb_break),
        .push_req  (push_req),
        .push_ent  (push_ent)
    );

    uart_rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_on  (fifo_on),
        .push_req (push_req),
        .pop      (rd_pop),
        .push_acc (push_acc),
        .pop_seen (pop_seen),
        .wr_slot  (wr_slot),
        .rd_pos   (rd_pos),
        .ovr_tag  (ovr_tag),
        .cnt_nxt  (cnt_nxt),
        .full     (buf_full),
        .empty    (buf_empty),
        .overrun  (overrun)
    );

    uart_rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_acc),
        .wr_slot (wr_slot),
        .wr_ent  (push_ent),
        .ovr_tag (ovr_tag),
        .rd_pos  (rd_pos),
        .cap     (pop_seen),
        .rd_ent  (head),
        .rd_err  (rd_err)
    );

    uart_rxq_trig #(.TRIG_LEVEL(TRIG_LEVEL), .CNT_W(CNT_W)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_acc  (push_acc),
        .pop_seen  (pop_seen),
        .cnt_nxt   (cnt_nxt),
        .lvl_wr    (lvl_wr),
        .lvl_wdata (lvl_wdata),
        .lvl_q     (lvl_q),
        .irq       (rx_irq)
    );

    // Present the head entry on the read port.
    always_comb begin
        rd_entry = head;
    end
endmodule

// File: rtl/uart_rxq_chk.sv
// Port-level properties of the receive queue, bound to every uart_rxq instance.
module uart_rxq_chk (
    input logic clk,
    input logic rst_n,
    input logic fifo_on,
    input logic loop_on,
    input logic rx_strobe,
    input logic rx_break,
    input logic lb_strobe,
    input logic lb_break,
    input logic rd_pop,
    input logic buf_full,
    input logic buf_empty,
    input logic rx_irq,
    input logic overrun
);
    // R3
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_full && buf_empty));

    // R4
    drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && fifo_on == $past(fifo_on) && !loop_on && rx_strobe) |=> overrun);

    // R5
    irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> !buf_empty);

    // R7
    mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on != $past(fifo_on)) |=> (buf_empty && !buf_full));

    // R9
    loop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_on && !lb_strobe && !lb_break && buf_empty) |=> buf_empty);

    // R11
    hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_on && !$past(fifo_on) && !buf_empty) |-> buf_full);
endmodule

bind uart_rxq uart_rxq_chk u_rxq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_on   (fifo_on),
    .loop_on   (loop_on),
    .rx_strobe (rx_strobe),
    .rx_break  (rx_break),
    .lb_strobe (lb_strobe),
    .lb_break  (lb_break),
    .rd_pop    (rd_pop),
    .buf_full  (buf_full),
    .buf_empty (buf_empty),
    .rx_irq    (rx_irq),
    .overrun   (overrun)
);

// File: tb/uart_rxq_test.sv
`timescale 1ns/1ps
module uart_rxq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_on = 1'b1;
    logic        loop_on = 1'b0;
    logic        rx_strobe = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        rx_frm_err = 1'b0;
    logic        rx_par_err = 1'b0;
    logic        rx_break = 1'b0;
    logic        lb_strobe = 1'b0;
    logic [7:0]  lb_char = '0;
    logic        lb_break = 1'b0;
    logic        rd_pop = 1'b0;
    logic [11:0] rd_entry;
    logic [3:0]  rd_err;
    logic        lvl_wr = 1'b0;
    logic [5:0]  lvl_wdata = '0;
    logic [5:0]  lvl_q;
    logic        buf_full;
    logic        buf_empty;
    logic        rx_irq;
    logic        overrun;

    int checks = 0;
    int fails  = 0;
    logic [11:0] exp_q[$];
    int  mcnt  = 0;
    int  mdepth = 16;
    bit  movr  = 1'b0;

    always #2 clk = ~clk;

    uart_rxq uut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: model acceptance and record the expected entry.
    task automatic model_push(input logic [11:0] ent);
        if (mcnt < mdepth) begin
            exp_q.push_back(ent | (movr ? 12'h800 : 12'h000));
            movr = 1'b0;
            mcnt++;
        end else begin
            movr = 1'b1;
        end
    endtask

    task automatic push_ext(input logic [7:0] c, input bit fe, input bit pe);
        @(negedge clk);
        rx_strobe = 1'b1; rx_char = c; rx_frm_err = fe; rx_par_err = pe;
        if (!loop_on) model_push({2'b00, pe, fe, c});
        @(negedge clk);
        rx_strobe = 1'b0; rx_frm_err = 1'b0; rx_par_err = 1'b0;
    endtask

    task automatic push_lb(input logic [7:0] c);
        @(negedge clk);
        lb_strobe = 1'b1; lb_char = c;
        if (loop_on) model_push({4'b0000, c});
        @(negedge clk);
        lb_strobe = 1'b0;
    endtask

    task automatic brk(input bit on_lb);
        @(negedge clk);
        if (on_lb) lb_break = 1'b1; else rx_break = 1'b1;
        if (on_lb == loop_on) model_push(12'h400);
        @(negedge clk);
        lb_break = 1'b0; rx_break = 1'b0;
    endtask

    // Monitor: compare the head entry against the scoreboard, then check tags.
    task automatic pop_chk(input string req);
        logic [11:0] e;
        @(negedge clk);
        rd_pop = 1'b1;
        #0.5;
        if (mcnt > 0) begin
            e = exp_q.pop_front();
            mcnt--;
            chk(rd_entry == e, req, rd_entry, e);
        end else begin
            e = rd_entry;
        end
        @(negedge clk);
        rd_pop = 1'b0;
        chk(rd_err == e[11:8], {req, " R10 tags"}, rd_err, e[11:8]);
    endtask

    task automatic pop_empty();
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic set_mode(input bit m);
        @(negedge clk);
        fifo_on = m;
        @(negedge clk);
        exp_q.delete();
        mcnt = 0; movr = 1'b0; mdepth = m ? 16 : 1;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(buf_empty && !buf_full && !rx_irq && !overrun && rd_err == 0, "R1 flags", {buf_empty, buf_full, rx_irq, overrun}, 4'b1000);
        chk(lvl_q == 6'h12, "R1 level", lvl_q, 6'h12);

        // R2 / R5 single character with framing tag
        push_ext(8'h41, 1'b1, 1'b0);
        chk(!buf_empty && rx_irq, "R5 rise", {buf_empty, rx_irq}, 2'b01);
        pop_chk("R2 single");
        chk(buf_empty && !rx_irq, "R5 fall", {buf_empty, rx_irq}, 2'b10);

        // R3 / R4 fill, overflow, tagged refill, wrap
        for (int i = 0; i < 16; i++) push_ext(8'h10 + 8'(i), i[0], i[1]);
        chk(buf_full && !buf_empty, "R3 full", {buf_full, buf_empty}, 2'b10);
        push_ext(8'hEE, 1'b0, 1'b0);
        chk(overrun == 1'b1, "R4 pulse", overrun, 1);
        @(negedge clk);
        chk(overrun == 1'b0, "R4 pulse end", overrun, 0);
        pop_chk("R2 head after overflow");
        chk(!buf_full, "R3 not full", buf_full, 0);
        push_ext(8'h99, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) pop_chk("R4 R2 drain");
        chk(buf_empty && !rx_irq, "R3 empty", {buf_empty, rx_irq}, 2'b10);

        // R10 pop on empty leaves pointers
        pop_empty();
        chk(buf_empty, "R10 empty kept", buf_empty, 1);
        push_ext(8'h5A, 1'b0, 1'b1);
        pop_chk("R10 after empty pop");

        // R8 break, and break beats a character
        brk(1'b0);
        pop_chk("R8 break");
        @(negedge clk);
        rx_strobe = 1'b1; rx_char = 8'h77; rx_break = 1'b1;
        model_push(12'h400);
        @(negedge clk);
        rx_strobe = 1'b0; rx_break = 1'b0;
        pop_chk("R8 precedence");

        // R9 loopback gating
        @(negedge clk); loop_on = 1'b1;
        push_ext(8'h11, 1'b0, 1'b0);
        brk(1'b0);
        chk(buf_empty, "R9 ext ignored", buf_empty, 1);
        push_lb(8'h22);
        brk(1'b1);
        pop_chk("R9 lb char");
        pop_chk("R9 lb break");
        @(negedge clk); loop_on = 1'b0;
        push_lb(8'h33);
        brk(1'b1);
        chk(buf_empty, "R9 lb ignored", buf_empty, 1);

        // R6 level register does not move the trigger
        @(negedge clk); lvl_wr = 1'b1; lvl_wdata = 6'h05;
        @(negedge clk); lvl_wr = 1'b0;
        chk(lvl_q == 6'h05, "R6 level", lvl_q, 6'h05);
        push_ext(8'h01, 1'b0, 1'b0);
        chk(rx_irq, "R6 trigger fixed", rx_irq, 1);
        push_ext(8'h02, 1'b0, 1'b0);
        push_ext(8'h03, 1'b0, 1'b0);

        // R7 mode change flush, irq kept
        set_mode(1'b0);
        chk(buf_empty && !buf_full, "R7 flush", {buf_empty, buf_full}, 2'b10);
        chk(rx_irq, "R7 irq kept", rx_irq, 1);
        pop_empty();
        chk(!rx_irq, "R5 pop empty clears", rx_irq, 0);

        // R11 holding mode
        push_ext(8'hA1, 1'b0, 1'b0);
        chk(buf_full && !buf_empty && rx_irq, "R11 held", {buf_full, buf_empty, rx_irq}, 3'b101);
        push_ext(8'hB2, 1'b0, 1'b0);
        chk(overrun, "R11 overrun", overrun, 1);
        pop_chk("R11 keeps first");
        push_ext(8'hC3, 1'b0, 1'b0);
        pop_chk("R11 ovr tag slot0");
        set_mode(1'b1);
        push_ext(8'hD4, 1'b0, 1'b0);
        push_ext(8'hD5, 1'b0, 1'b0);
        pop_chk("R7 buffered again");
        pop_chk("R7 buffered again 2");
        chk(buf_empty, "R3 final empty", buf_empty, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule